// File: doc/BRIEF.md
# Ethernet Transmit Pause Gate

This block enforces received flow-control holds on the transmit side of an Ethernet MAC. When the receive path reports a validated PAUSE control frame, and receive flow control is enabled, the block loads the frame's 16-bit pause value into a countdown timer. The timer counts in pause quanta. One quantum is a fixed number of bit-times, so its length in clock cycles follows the selected link speed. While the timer is non-zero, only control frames may start. Data frames wait until the count runs out, until a zero-valued pause frame cancels the hold, or until flow control is switched off.

The transmit path asks to start a frame through a valid/ready handshake. `tx_start_valid` presents a start request, and `tx_start_is_ctrl` marks it as a control frame. `tx_start_ready` is the grant. Back-pressure rules:
- A requester that sees ready low keeps valid and the control flag steady, and waits.
- A frame starts on the cycle in which both valid and ready are high.
- Ready depends only on the pause state and the control flag, never on valid.
- The gate acts only at frame start. A frame that has already started carries on to its end, even if a pause arrives meanwhile.

The countdown runs whether or not a frame is on the wire, so a pause overlaps any frame in flight.

Top module: `pause_gate`

## Requirements
- R1: After reset, `pause_active` is 0 and `tx_start_ready` is 1.
- R2: A pause strobe seen while `rx_fc_en` is 0 is ignored: `pause_active` stays 0 in the next cycle.
- R3: A pause strobe with `rx_fc_en` at 1 and a non-zero value sets `pause_active` in the next cycle, whatever the transmit request inputs are doing.
- R4: One quantum lasts QUANTUM_BITS / GIG_BITS_PER_CYC cycles at 1000 Mb/s. It is SPEED_STEP times longer at 100 Mb/s and SPEED_STEP squared times longer at 10 Mb/s. The `link_speed` encoding is 2'b00 = 10 Mb/s, 2'b01 = 100 Mb/s, 2'b10 = 1000 Mb/s, and 2'b11 = 1000 Mb/s. A pause of value V keeps `pause_active` high for exactly V quanta.
- R5: A pause strobe with value 0, while flow control is enabled, clears `pause_active` in the next cycle.
- R6: A pause strobe during an active pause replaces the remaining count with the new value and restarts the current quantum. The hold then lasts exactly new-value quanta from that strobe.
- R7: While `pause_active` is 1, a data request (`tx_start_is_ctrl` = 0) sees `tx_start_ready` = 0.
- R8: A control request (`tx_start_is_ctrl` = 1) always sees `tx_start_ready` = 1.
- R9: Driving `rx_fc_en` low clears any active pause in the next cycle.
- R10: When `pause_active` returns to 0, data requests are granted again (`tx_start_ready` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_fc_en | input | 1 | Receive flow-control enable |
| link_speed | input | 2 | Link speed select (see R4) |
| rx_pause_stb | input | 1 | One-cycle strobe: validated PAUSE frame received |
| rx_pause_val | input | TIMER_W | Pause value of that frame, in quanta |
| tx_start_valid | input | 1 | Transmit frame start request |
| tx_start_is_ctrl | input | 1 | Requested frame is a control frame |
| tx_start_ready | output | 1 | Grant: the requested frame may start |
| pause_active | output | 1 | A pause hold is in force |

## Verification
A strobe acts on `pause_active` one clock edge after it is sampled. A hold of value V then lasts exactly V times the per-speed quantum length in cycles. `tx_start_ready` follows its inputs and the pause state within the same cycle. The bench drives inputs on falling edges and samples at the next falling edge. It counts the falling edges on which `pause_active` is high and compares that count with the product it computes from the value and the speed. The sweep covers every speed code and a range of values, and the reload, cancel and disable cases are timed from their own strobe in the same way.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [1:0] {
    SPD_10M    = 2'b00,
    SPD_100M   = 2'b01,
    SPD_1G     = 2'b10,
    SPD_1G_ALT = 2'b11
  } link_speed_e;
endpackage

// File: rtl/pg_quantum_tick.sv
module pg_quantum_tick #(
  parameter int QUANTUM_BITS     = 512,
  parameter int GIG_BITS_PER_CYC = 8,
  parameter int SPEED_STEP       = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] speed,
  output logic       tick
);
  import pg_pkg::*;

  localparam int LIM_1G   = QUANTUM_BITS / GIG_BITS_PER_CYC;
  localparam int LIM_100M = LIM_1G * SPEED_STEP;
  localparam int LIM_10M  = LIM_100M * SPEED_STEP;
  localparam int PW       = $clog2(LIM_10M + 1);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] last;
  logic          at_end;

  // cycle index of the final cycle of a quantum at the current speed
  always_comb begin
    unique case (link_speed_e'(speed))
      SPD_10M:  last = PW'(LIM_10M - 1);
      SPD_100M: last = PW'(LIM_100M - 1);
      default:  last = PW'(LIM_1G - 1);
    endcase
  end

  assign at_end = (pre_q >= last);
  assign tick   = run && !restart && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (!run || restart || at_end) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/pg_pause_counter.sv
module pg_pause_counter #(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fc_en,
  input  logic               load,
  input  logic [TIMER_W-1:0] load_val,
  input  logic               tick,
  output logic               active
);
  logic [TIMER_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!fc_en) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/pg_tx_grant.sv
module pg_tx_grant (
  input  logic paused,
  input  logic req_is_ctrl,
  output logic grant
);
  assign grant = !paused || req_is_ctrl;
endmodule

// File: rtl/pause_gate.sv
module pause_gate #(
  parameter int TIMER_W          = 16,
  parameter int QUANTUM_BITS     = 512,
  parameter int GIG_BITS_PER_CYC = 8,
  parameter int SPEED_STEP       = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_fc_en,
  input  logic [1:0]         link_speed,
  input  logic               rx_pause_stb,
  input  logic [TIMER_W-1:0] rx_pause_val,
  input  logic               tx_start_valid,
  input  logic               tx_start_is_ctrl,
  output logic               tx_start_ready,
  output logic               pause_active
);
  logic load;
  logic tick;
  logic active;

  assign load = rx_fc_en && rx_pause_stb;

  pg_quantum_tick #(
    .QUANTUM_BITS    (QUANTUM_BITS),
    .GIG_BITS_PER_CYC(GIG_BITS_PER_CYC),
    .SPEED_STEP      (SPEED_STEP)
  ) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (active),
    .restart(load),
    .speed  (link_speed),
    .tick   (tick)
  );

  pg_pause_counter #(.TIMER_W(TIMER_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .fc_en   (rx_fc_en),
    .load    (load),
    .load_val(rx_pause_val),
    .tick    (tick),
    .active  (active)
  );

  pg_tx_grant u_grant (
    .paused     (active),
    .req_is_ctrl(tx_start_is_ctrl),
    .grant      (tx_start_ready)
  );

  assign pause_active = active;

  // tx_start_valid is part of the handshake only; the grant never depends on it
  logic unused_valid;
  assign unused_valid = tx_start_valid;
endmodule

// File: rtl/pause_gate_chk.sv
module pause_gate_chk #(
  parameter int TIMER_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rx_fc_en,
  input logic               rx_pause_stb,
  input logic [TIMER_W-1:0] rx_pause_val,
  input logic               tx_start_valid,
  input logic               tx_start_is_ctrl,
  input logic               tx_start_ready,
  input logic               pause_active
);
  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !pause_active);

  p_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_fc_en && rx_pause_stb) |=> !pause_active);

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fc_en && rx_pause_stb && rx_pause_val != '0) |=> pause_active);

  p_zero_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fc_en && rx_pause_stb && rx_pause_val == '0) |=> !pause_active);

  p_only_by_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pause_active) |-> $past(rx_fc_en && rx_pause_stb));

  p_hold_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_active && tx_start_valid && !tx_start_is_ctrl) |-> !tx_start_ready);

  p_ctrl_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start_is_ctrl |-> tx_start_ready);

  p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_fc_en |=> !pause_active);

  p_resume_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_active |-> tx_start_ready);
endmodule

bind pause_gate pause_gate_chk #(.TIMER_W(TIMER_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .rx_fc_en        (rx_fc_en),
  .rx_pause_stb    (rx_pause_stb),
  .rx_pause_val    (rx_pause_val),
  .tx_start_valid  (tx_start_valid),
  .tx_start_is_ctrl(tx_start_is_ctrl),
  .tx_start_ready  (tx_start_ready),
  .pause_active    (pause_active)
);

// File: tb/tb_pause_gate.sv
module tb_pause_gate;
  localparam int CLK_PERIOD = 10;
  localparam int TW   = 16;
  localparam int QB   = 16;
  localparam int GBPC = 8;
  localparam int STEP = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_fc_en = 1'b0;
  logic [1:0]    link_speed = 2'b10;
  logic          rx_pause_stb = 1'b0;
  logic [TW-1:0] rx_pause_val = '0;
  logic          tx_start_valid = 1'b0;
  logic          tx_start_is_ctrl = 1'b0;
  logic          tx_start_ready;
  logic          pause_active;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pause_gate #(.TIMER_W(TW), .QUANTUM_BITS(QB), .GIG_BITS_PER_CYC(GBPC),
               .SPEED_STEP(STEP)) dut (
    .clk(clk), .rst_n(rst_n), .rx_fc_en(rx_fc_en), .link_speed(link_speed),
    .rx_pause_stb(rx_pause_stb), .rx_pause_val(rx_pause_val),
    .tx_start_valid(tx_start_valid), .tx_start_is_ctrl(tx_start_is_ctrl),
    .tx_start_ready(tx_start_ready), .pause_active(pause_active)
  );

  function automatic int quantum_cycles(input logic [1:0] spd);
    int base = QB / GBPC;
    case (spd)
      2'b00:   return base * STEP * STEP;
      2'b01:   return base * STEP;
      default: return base;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive strobe at a falling edge; return at the next falling edge with strobe removed
  task automatic strobe(input logic [TW-1:0] v);
    rx_pause_val = v;
    rx_pause_stb = 1'b1;
    @(negedge clk);
    rx_pause_stb = 1'b0;
  endtask

  // counts falling edges with pause_active high, including the current one
  task automatic measure(output int n);
    n = 0;
    while (pause_active && n < 100000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pause_active", pause_active, 0);
    check("R1 ready", tx_start_ready, 1);

    // R2 strobe ignored with flow control off
    tx_start_valid = 1'b1;
    strobe(16'd5);
    check("R2 ignored", pause_active, 0);
    check("R2 ready", tx_start_ready, 1);

    rx_fc_en = 1'b1;
    // R3/R4/R7/R8/R10 sweep over all speed codes and values 1..6
    for (int s = 0; s < 4; s++) begin
      for (int v = 1; v <= 6; v++) begin
        link_speed = 2'(s);
        tx_start_valid = (v % 2) == 1;
        tx_start_is_ctrl = 1'b0;
        strobe(TW'(v));
        check("R3 active after strobe", pause_active, 1);
        check("R7 data held", tx_start_ready, 0);
        tx_start_is_ctrl = 1'b1;
        #1;
        check("R8 ctrl granted", tx_start_ready, 1);
        tx_start_is_ctrl = 1'b0;
        measure(n);
        check("R4 duration", n, v * quantum_cycles(2'(s)));
        check("R10 resumed", tx_start_ready, 1);
        @(negedge clk);
      end
    end

    // R5 zero value cancels
    link_speed = 2'b01;
    strobe(16'd4);
    repeat (7) @(negedge clk);
    strobe(16'd0);
    check("R5 zero cancels", pause_active, 0);
    check("R5 ready", tx_start_ready, 1);

    // R6 reload restarts from new value
    link_speed = 2'b10;
    strobe(16'd5);
    repeat (3) @(negedge clk);
    strobe(16'd2);
    measure(n);
    check("R6 reload", n, 2 * quantum_cycles(2'b10));
    strobe(16'd1);
    @(negedge clk);
    strobe(16'd7);
    measure(n);
    check("R6 reload longer", n, 7 * quantum_cycles(2'b10));

    // R9 disable clears
    link_speed = 2'b00;
    strobe(16'd3);
    repeat (11) @(negedge clk);
    rx_fc_en = 1'b0;
    @(negedge clk);
    check("R9 disable clears", pause_active, 0);
    check("R9 ready", tx_start_ready, 1);
    rx_fc_en = 1'b1;
    @(negedge clk);
    check("R9 stays clear", pause_active, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule